// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block combines an 8-bit up-counting timer and a watchdog counter that share one 8-bit prescaler. A byte-wide option register configures the block. The timer advances either once per instruction cycle or on edges of an external pin. The pin is synchronized and its active edge is selectable. The prescaler serves one counter at a time. Placed in front of the timer, it divides the timer source by 2 to 256. Placed behind the watchdog, it divides the watchdog tick by 1 to 128.

An instruction cycle is `PHASES` oscillator clocks long. The external path is sampled twice per instruction cycle, on phase 0 and on phase `PHASES/2`. A timer rollover from all-ones to zero sets a sticky overflow flag. The watchdog counts ticks from its own oscillator, which arrive here as a one-clock pulse input. When it reaches `WDG_TERM` steps, it emits a one-clock reset request and clears its timeout status. The clear-watchdog and sleep-entry strobes restart it.

Top module: `tmr_wdt_unit`

## Requirements
- R1: After a synchronous reset, `opt_q` = FFh, `tmr_q` = 0, `ovf_flag` = 0, `wdg_reset` = 0 and `no_timeout` = 1.
- R2: A write to the option register appears on `opt_q` one clock later. Bit 5 selects the timer source (1 = pin), bit 4 selects the pin edge (0 = rising, 1 = falling), bit 3 assigns the prescaler (0 = timer, 1 = watchdog) and bits 2..0 form the ratio field PS. Bits 7 and 6 are stored but have no effect inside the block.
- R3: With the prescaler on the watchdog and bit 5 clear, the timer rises by exactly one per instruction cycle (`PHASES` clocks) and never by more than one per clock.
- R4: A timer write loads the value on the next clock. The following two instruction-cycle boundaries produce no increment. When the prescaler is assigned to the timer, the write also clears the prescaler.
- R5: With the prescaler on the timer, the timer advances once per 2^(PS+1) source events.
- R6: In pin mode, each selected edge on `ext_pin` counts as one source event, provided each level is held for at least `PHASES` clocks.
- R7: A rollover from FFh to 00h sets `ovf_flag` in the same clock as the wrap. `ovf_clr` clears the flag, and setting wins over clearing in the same clock.
- R8: With the prescaler on the watchdog, one watchdog step is taken per 2^PS ticks; otherwise one step per tick. On the `WDG_TERM`-th step the block pulses `wdg_reset` for one clock, drives `no_timeout` low and restarts the count.
- R9: `wdg_clear` and `sleep_entry` zero the watchdog count and set `no_timeout`. When the prescaler is on the watchdog, they also clear the prescaler.
- R10: While `wdg_enable` is low, the watchdog never expires.
- R11: While `sleep_active` is high, the timer holds its value, and the watchdog keeps stepping and can expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| wdg_enable | input | 1 | Static watchdog enable |
| opt_wr_en | input | 1 | Option register write strobe |
| opt_wr_data | input | 8 | Option register write value |
| tmr_wr_en | input | 1 | Timer write strobe |
| tmr_wr_data | input | TW | Timer write value |
| ovf_clr | input | 1 | Clears the overflow flag |
| ext_pin | input | 1 | Asynchronous external count input |
| wdg_tick | input | 1 | One-clock pulse from the watchdog oscillator |
| wdg_clear | input | 1 | Clear-watchdog strobe |
| sleep_entry | input | 1 | Sleep-entry strobe |
| sleep_active | input | 1 | High while the core sleeps |
| opt_q | output | 8 | Option register contents |
| tmr_q | output | TW | Timer value |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| wdg_reset | output | 1 | One-clock watchdog reset request |
| no_timeout | output | 1 | Timeout status, low after an expiry |

## Verification
The prescaler cannot be read, so its clearing on a timer write is the hardest effect to observe from the ports. The stimulus first sets the prescaler to ratio 2 in pin mode. It feeds an odd number of edges so the prescaler output stands high, then writes the timer. A single further edge then adds one count only if the prescaler was cleared. The watchdog ratio is exercised the same way: a clear is followed by exactly one tick less than the terminal number of prescaled steps, then one more tick.

// File: rtl/tmw_pkg.sv
package tmw_pkg;
  localparam int OPT_W   = 8;
  localparam int PRE_W   = 8;
  localparam int RATIO_W = 3;
  localparam logic [OPT_W-1:0] OPT_RESET = 8'hFF;

  typedef struct packed {
    logic               pullup_off;
    logic               irq_rise;
    logic               src_pin;
    logic               pin_fall;
    logic               pre_to_wdg;
    logic [RATIO_W-1:0] ratio;
  } opt_t;

  // low-order ones below the ratio position: PS=0 -> 0, PS=3 -> 0000_0111
  function automatic logic [PRE_W-1:0] ratio_mask(input logic [RATIO_W-1:0] r);
    logic [PRE_W-1:0] m;
    for (int i = 0; i < PRE_W; i++) m[i] = (i < int'(r));
    return m;
  endfunction
endpackage

// File: rtl/tmw_phase.sv
module tmw_phase #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst,
  output logic cyc_stb,
  output logic smp_stb
);
  localparam int PW = (PHASES > 2) ? $clog2(PHASES) : 1;

  logic [PW-1:0] ph_q;

  assign cyc_stb = (ph_q == PW'(PHASES - 1));
  assign smp_stb = (ph_q == '0) || (ph_q == PW'(PHASES / 2));

  always_ff @(posedge clk) begin
    if (rst)          ph_q <= '0;
    else if (cyc_stb) ph_q <= '0;
    else              ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/tmw_pin_edge.sv
module tmw_pin_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall,
  output logic lvl,
  output logic evt
);
  logic s1_q, s2_q, prev_q;

  assign lvl = s2_q ^ fall;
  assign evt = lvl & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= lvl;
    end
  end
endmodule

// File: rtl/tmw_prescaler.sv
module tmw_prescaler
  import tmw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               adv,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tap,
  output logic               at_mask
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] msk;

  assign msk     = ratio_mask(ratio);
  assign tap     = cnt_q[ratio];
  assign at_mask = ((cnt_q & msk) == msk);

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmw_timer.sv
module tmw_timer #(
  parameter int TW          = 8,
  parameter int HOLD_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_stb,
  input  logic          smp_stb,
  input  logic          use_sampler,
  input  logic          sample_lvl,
  input  logic          freeze,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_data,
  input  logic          ovf_clr,
  output logic [TW-1:0] cnt_q,
  output logic          ovf_q
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] hold_q;
  logic          smp_q;
  logic          inc_raw;
  logic          inc;

  assign inc_raw = use_sampler ? (smp_stb & sample_lvl & ~smp_q) : cyc_stb;
  assign inc     = inc_raw & (hold_q == '0) & ~freeze & ~wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      smp_q  <= 1'b1;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (smp_stb) smp_q <= sample_lvl;

      if (wr_en)                          hold_q <= HW'(HOLD_CYCLES);
      else if (cyc_stb && hold_q != '0)   hold_q <= hold_q - 1'b1;

      if (wr_en)    cnt_q <= wr_data;
      else if (inc) cnt_q <= cnt_q + 1'b1;

      if (inc && (&cnt_q)) ovf_q <= 1'b1;
      else if (ovf_clr)    ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmw_watchdog.sv
module tmw_watchdog #(
  parameter int TERM = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic step,
  input  logic kick,
  output logic expire,
  output logic rst_req_q,
  output logic ok_q
);
  localparam int WW = (TERM > 2) ? $clog2(TERM) : 1;

  logic [WW-1:0] cnt_q;

  assign expire = enable & step & ~kick & (cnt_q == WW'(TERM - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      ok_q      <= 1'b1;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= expire;
      if (kick) begin
        cnt_q <= '0;
        ok_q  <= 1'b1;
      end else if (expire) begin
        cnt_q <= '0;
        ok_q  <= 1'b0;
      end else if (enable && step) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_wdt_unit.sv
module tmr_wdt_unit
  import tmw_pkg::*;
#(
  parameter int TW       = 8,
  parameter int PHASES   = 4,
  parameter int WDG_TERM = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wdg_enable,
  input  logic             opt_wr_en,
  input  logic [OPT_W-1:0] opt_wr_data,
  input  logic             tmr_wr_en,
  input  logic [TW-1:0]    tmr_wr_data,
  input  logic             ovf_clr,
  input  logic             ext_pin,
  input  logic             wdg_tick,
  input  logic             wdg_clear,
  input  logic             sleep_entry,
  input  logic             sleep_active,
  output logic [OPT_W-1:0] opt_q,
  output logic [TW-1:0]    tmr_q,
  output logic             ovf_flag,
  output logic             wdg_reset,
  output logic             no_timeout
);
  opt_t opt_r;
  logic cyc_stb, smp_stb;
  logic pin_lvl, pin_evt;
  logic pre_tap, pre_at_mask, pre_clr, pre_adv;
  logic kick, expire, wdg_step;
  logic use_sampler, sample_lvl;

  always_ff @(posedge clk) begin
    if (rst)            opt_r <= opt_t'(OPT_RESET);
    else if (opt_wr_en) opt_r <= opt_t'(opt_wr_data);
  end
  assign opt_q = opt_r;

  tmw_phase #(.PHASES(PHASES)) phase_i (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .smp_stb(smp_stb)
  );

  tmw_pin_edge pin_i (
    .clk(clk), .rst(rst), .pin(ext_pin), .fall(opt_r.pin_fall),
    .lvl(pin_lvl), .evt(pin_evt)
  );

  assign kick    = wdg_clear | sleep_entry;
  assign pre_adv = opt_r.pre_to_wdg ? wdg_tick
                 : (~sleep_active & (opt_r.src_pin ? pin_evt : cyc_stb));
  assign pre_clr = opt_r.pre_to_wdg ? (kick | expire) : tmr_wr_en;

  tmw_prescaler pre_i (
    .clk(clk), .rst(rst), .clr(pre_clr), .adv(pre_adv), .ratio(opt_r.ratio),
    .tap(pre_tap), .at_mask(pre_at_mask)
  );

  assign use_sampler = ~opt_r.pre_to_wdg | opt_r.src_pin;
  assign sample_lvl  = opt_r.pre_to_wdg ? pin_lvl : pre_tap;

  tmw_timer #(.TW(TW), .HOLD_CYCLES(2)) tmr_i (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .smp_stb(smp_stb),
    .use_sampler(use_sampler), .sample_lvl(sample_lvl), .freeze(sleep_active),
    .wr_en(tmr_wr_en), .wr_data(tmr_wr_data), .ovf_clr(ovf_clr),
    .cnt_q(tmr_q), .ovf_q(ovf_flag)
  );

  assign wdg_step = wdg_tick & (opt_r.pre_to_wdg ? pre_at_mask : 1'b1);

  tmw_watchdog #(.TERM(WDG_TERM)) wdg_i (
    .clk(clk), .rst(rst), .enable(wdg_enable), .step(wdg_step), .kick(kick),
    .expire(expire), .rst_req_q(wdg_reset), .ok_q(no_timeout)
  );
endmodule

// File: rtl/tmr_wdt_unit_chk.sv
module tmr_wdt_unit_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wdg_enable,
  input logic          opt_wr_en,
  input logic [7:0]    opt_wr_data,
  input logic          tmr_wr_en,
  input logic [TW-1:0] tmr_wr_data,
  input logic          wdg_clear,
  input logic          sleep_entry,
  input logic          sleep_active,
  input logic [7:0]    opt_q,
  input logic [TW-1:0] tmr_q,
  input logic          ovf_flag,
  input logic          wdg_reset,
  input logic          no_timeout
);
  p_opt_load_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(opt_wr_en) && !$past(rst)) |-> (opt_q == $past(opt_wr_data)));

  p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(tmr_wr_en) && !$past(rst)) |->
      (tmr_q == $past(tmr_q) || tmr_q == TW'($past(tmr_q) + 1'b1)));

  p_write_load_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(tmr_wr_en) && !$past(rst)) |-> (tmr_q == $past(tmr_wr_data)));

  p_hold_after_write_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(tmr_wr_en, 2) && !$past(tmr_wr_en) && !$past(rst) && !$past(rst, 2))
      |-> $stable(tmr_q));

  p_no_overflow_miss_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tmr_wr_en) && ($past(tmr_q) == {TW{1'b1}}) && (tmr_q == '0))
      |-> ovf_flag);

  p_reset_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    wdg_reset |=> !wdg_reset);

  p_timeout_status_r8: assert property (@(posedge clk) disable iff (rst)
    wdg_reset |-> !no_timeout);

  p_kick_status_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(wdg_clear || sleep_entry) && !$past(rst)) |-> no_timeout);

  p_disabled_r10: assert property (@(posedge clk) disable iff (rst)
    (!wdg_enable && !$past(wdg_enable)) |-> !wdg_reset);

  p_sleep_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(sleep_active) && !$past(tmr_wr_en) && !$past(rst)) |-> $stable(tmr_q));
endmodule

bind tmr_wdt_unit tmr_wdt_unit_chk #(.TW(TW)) chk_i (
  .clk(clk), .rst(rst), .wdg_enable(wdg_enable),
  .opt_wr_en(opt_wr_en), .opt_wr_data(opt_wr_data),
  .tmr_wr_en(tmr_wr_en), .tmr_wr_data(tmr_wr_data),
  .wdg_clear(wdg_clear), .sleep_entry(sleep_entry), .sleep_active(sleep_active),
  .opt_q(opt_q), .tmr_q(tmr_q), .ovf_flag(ovf_flag),
  .wdg_reset(wdg_reset), .no_timeout(no_timeout)
);

// File: tb/tmr_wdt_unit_tb_top.sv
module tmr_wdt_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PH   = 4;
  localparam int TERM = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wdg_enable = 1'b1;
  logic opt_wr_en = 1'b0;
  logic [7:0] opt_wr_data = '0;
  logic tmr_wr_en = 1'b0;
  logic [7:0] tmr_wr_data = '0;
  logic ovf_clr = 1'b0, ext_pin = 1'b0, wdg_tick = 1'b0;
  logic wdg_clear = 1'b0, sleep_entry = 1'b0, sleep_active = 1'b0;
  logic [7:0] opt_q, tmr_q;
  logic ovf_flag, wdg_reset, no_timeout;

  int checks = 0, fails = 0, n_wrst = 0;
  bit live = 0, done = 0;

  tmr_wdt_unit #(.TW(8), .PHASES(PH), .WDG_TERM(TERM)) dut_i (
    .clk(clk), .rst(rst), .wdg_enable(wdg_enable),
    .opt_wr_en(opt_wr_en), .opt_wr_data(opt_wr_data),
    .tmr_wr_en(tmr_wr_en), .tmr_wr_data(tmr_wr_data), .ovf_clr(ovf_clr),
    .ext_pin(ext_pin), .wdg_tick(wdg_tick), .wdg_clear(wdg_clear),
    .sleep_entry(sleep_entry), .sleep_active(sleep_active),
    .opt_q(opt_q), .tmr_q(tmr_q), .ovf_flag(ovf_flag),
    .wdg_reset(wdg_reset), .no_timeout(no_timeout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_phase = 0, m_s1 = 0, m_s2 = 0, m_prev = 1, m_pre = 0, m_smp = 1, m_hold = 0;
  int m_tmr = 0, m_ovf = 0, m_wcnt = 0, m_ok = 1, m_wrst = 0, m_opt = 255;
  int psa, tsrc, fall, ps, cyc, smpt, sel, pevt, pre_adv, lvl, use_s, raw, tinc;
  int mask, wstep, kick, expire;
  int n_pre, n_tmr, n_ovf, n_hold, n_smp, n_wcnt, n_ok;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_s1 = 0; m_s2 = 0; m_prev = 1; m_pre = 0; m_smp = 1; m_hold = 0;
      m_tmr = 0; m_ovf = 0; m_wcnt = 0; m_ok = 1; m_wrst = 0; m_opt = 255;
    end else begin
      psa  = (m_opt >> 3) & 1;
      tsrc = (m_opt >> 5) & 1;
      fall = (m_opt >> 4) & 1;
      ps   = m_opt & 7;
      cyc  = (m_phase == PH - 1);
      smpt = (m_phase == 0) || (m_phase == PH / 2);
      sel  = m_s2 ^ fall;
      pevt = sel && !m_prev;
      pre_adv = psa ? int'(wdg_tick) : (!sleep_active && (tsrc ? pevt : cyc));
      lvl   = psa ? sel : ((m_pre >> ps) & 1);
      use_s = !psa || tsrc;
      raw   = use_s ? (smpt && lvl && !m_smp) : cyc;
      tinc  = raw && (m_hold == 0) && !sleep_active && !tmr_wr_en;
      mask  = (1 << ps) - 1;
      wstep = wdg_tick && (psa ? ((m_pre & mask) == mask) : 1);
      kick  = wdg_clear || sleep_entry;
      expire = wdg_enable && wstep && !kick && (m_wcnt == TERM - 1);

      n_pre  = (psa ? (kick || expire) : int'(tmr_wr_en)) ? 0 : (pre_adv ? (m_pre + 1) % 256 : m_pre);
      n_tmr  = tmr_wr_en ? int'(tmr_wr_data) : (tinc ? (m_tmr + 1) % 256 : m_tmr);
      n_ovf  = (tinc && m_tmr == 255) ? 1 : (ovf_clr ? 0 : m_ovf);
      n_hold = tmr_wr_en ? 2 : ((cyc && m_hold > 0) ? m_hold - 1 : m_hold);
      n_smp  = smpt ? lvl : m_smp;
      n_wcnt = kick ? 0 : (expire ? 0 : ((wdg_enable && wstep) ? m_wcnt + 1 : m_wcnt));
      n_ok   = kick ? 1 : (expire ? 0 : m_ok);

      m_wrst = expire;
      m_pre = n_pre; m_tmr = n_tmr; m_ovf = n_ovf; m_hold = n_hold; m_smp = n_smp;
      m_wcnt = n_wcnt; m_ok = n_ok;
      if (opt_wr_en) m_opt = int'(opt_wr_data);
      m_prev = sel; m_s2 = m_s1; m_s1 = int'(ext_pin);
      m_phase = (m_phase + 1) % PH;
    end
    live = 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live && !done) begin
      check("R3 timer vs model", int'(tmr_q), m_tmr);
      check("R2 option vs model", int'(opt_q), m_opt);
      check("R7 overflow vs model", int'(ovf_flag), m_ovf);
      check("R8 watchdog reset vs model", int'(wdg_reset), m_wrst);
      check("R9 timeout status vs model", int'(no_timeout), m_ok);
    end
  end

  always @(posedge clk) begin
    #1;
    if (wdg_reset) n_wrst++;
  end

  task automatic report();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_opt(input int v);
    opt_wr_en = 1; opt_wr_data = 8'(v); @(negedge clk); opt_wr_en = 0;
  endtask
  task automatic wr_tmr(input int v);
    tmr_wr_en = 1; tmr_wr_data = 8'(v); @(negedge clk); tmr_wr_en = 0;
  endtask
  task automatic ticks(input int n);
    repeat (n) begin wdg_tick = 1; @(negedge clk); wdg_tick = 0; @(negedge clk); end
  endtask
  task automatic kick_clear();
    wdg_clear = 1; @(negedge clk); wdg_clear = 0; @(negedge clk);
  endtask
  task automatic kick_sleep();
    sleep_entry = 1; @(negedge clk); sleep_entry = 0; @(negedge clk);
  endtask
  task automatic pin_pulses(input int n);
    repeat (n) begin ext_pin = 1; wait_clk(6); ext_pin = 0; wait_clk(6); end
  endtask
  task automatic do_reset();
    rst = 1; wait_clk(3); rst = 0; wait_clk(1);
  endtask

  int v;

  initial begin
    wait_clk(1);
    do_reset();
    // R1 reset state
    check("R1 opt_q", int'(opt_q), 8'hFF);
    check("R1 tmr_q", int'(tmr_q), 0);
    check("R1 ovf_flag", int'(ovf_flag), 0);
    check("R1 no_timeout", int'(no_timeout), 1);
    check("R1 wdg_reset", int'(wdg_reset), 0);

    // R2: prescaler to watchdog, PS=0, internal source
    wr_opt(8'h08);
    check("R2 option write", int'(opt_q), 8'h08);

    // R4 hold-off then R7 rollover
    wr_tmr(8'hFE);
    wait_clk(8);  check("R4 hold two cycles", int'(tmr_q), 8'hFE);
    wait_clk(4);  check("R4 resumes after hold", int'(tmr_q), 8'hFF);
    wait_clk(4);  check("R7 wraps to zero", int'(tmr_q), 0);
    check("R7 flag set on wrap", int'(ovf_flag), 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    check("R7 flag cleared", int'(ovf_flag), 0);

    // R3 one per instruction cycle
    v = int'(tmr_q);
    wait_clk(40);
    check("R3 ten cycles ten counts", int'(tmr_q), (v + 10) % 256);

    // R11 sleep freezes timer, watchdog still runs (R8 terminal count)
    sleep_active = 1;
    v = int'(tmr_q);
    ticks(15);
    check("R11 timer frozen in sleep", int'(tmr_q), v);
    check("R8 no expiry before term", n_wrst, 0);
    ticks(1);
    check("R11 watchdog expires in sleep", n_wrst, 1);
    check("R8 timeout status low", int'(no_timeout), 0);
    sleep_active = 0;

    // R9 clear and sleep strobes restart the watchdog
    kick_clear();
    check("R9 clear sets status", int'(no_timeout), 1);
    ticks(10); kick_clear(); ticks(10);
    check("R9 clear restarts count", n_wrst, 1);
    kick_sleep(); ticks(10);
    check("R9 sleep strobe restarts count", n_wrst, 1);

    // R8 prescaled watchdog, PS=2 -> one step per 4 ticks
    wr_opt(8'h0A);
    kick_clear();
    ticks(63);
    check("R8 prescaled not yet expired", n_wrst, 1);
    ticks(1);
    check("R8 prescaled expiry", n_wrst, 2);

    // R10 disabled watchdog
    wdg_enable = 0;
    do_reset();
    wr_opt(8'h08);
    ticks(40);
    check("R10 no expiry when disabled", n_wrst, 2);
    check("R10 status stays high", int'(no_timeout), 1);
    wdg_enable = 1;
    do_reset();

    // R5 prescaler on timer, internal source
    wr_opt(8'h01); wr_tmr(0); wait_clk(40);
    v = int'(tmr_q); wait_clk(160);
    check("R5 ratio 4", int'(tmr_q), (v + 10) % 256);
    wr_opt(8'h00); wr_tmr(0); wait_clk(40);
    v = int'(tmr_q); wait_clk(160);
    check("R5 ratio 2", int'(tmr_q), (v + 20) % 256);

    // R6 external pin, rising then falling, no prescaler
    wr_opt(8'h28); wait_clk(4); wr_tmr(0); wait_clk(12);
    pin_pulses(7); wait_clk(20);
    check("R6 rising edges", int'(tmr_q), 7);
    wr_opt(8'h38); wait_clk(12); wr_tmr(0); wait_clk(12);
    pin_pulses(5); wait_clk(20);
    check("R6 falling edges", int'(tmr_q), 5);

    // R5/R6 pin through prescaler ratio 2, then R4 prescaler clear
    wr_opt(8'h20); wait_clk(12); wr_tmr(0); wait_clk(12);
    pin_pulses(8); wait_clk(20);
    check("R5 pin edges divided by 2", int'(tmr_q), 4);
    pin_pulses(1); wait_clk(20);
    check("R5 odd edge counts", int'(tmr_q), 5);
    wr_tmr(8'h10); wait_clk(12);
    pin_pulses(1); wait_clk(20);
    check("R4 write clears prescaler", int'(tmr_q), 8'h11);

    wait_clk(4);
    report();
  end
endmodule